// File: doc/BRIEF.md
# Mode-Configurable Triple Memory Bank

Three equal banks of storage, called A, B and C, each one byte wide and `BANK_DEPTH` words deep, are combined by a 3-bit mode code into one of eight arrangements. In each arrangement a channel is a line buffer. A channel has a write pointer that stores one word per write cycle and a read pointer that returns one word per read cycle. Both pointers wrap at the channel's line length. Channels may be independent or wider (12-bit, built from a byte bank plus half of bank B). They may also be deeper, with banks concatenated so that the upper pointer bits choose the bank. In a cascade, the banks form a chain of line delays: each read of the first stage also feeds the next stage.

The block has three byte ports, A, B and C, all on one clock. Each port has its own write enable, write reset, read enable and read reset. The controls come as 3-bit vectors, with bit 0 for port A, bit 1 for port B and bit 2 for port C. Each output port reports, per nibble, whether it is driven in that cycle: bit 0 of `dout_oe_*` covers bits 3..0 and bit 1 covers bits 7..4. A nibble that is not driven reads as zero.

Top module: `tri_bank_fifo`

## Requirements
- R1: The mode register takes `mode_sel` only on a clock edge where all six reset inputs (`wr_rst` and `rd_rst`, all bits) are high. At any other edge a change of `mode_sel` has no effect. After `rst_n` the mode code is 0.
- R2: Code 0 gives three independent 8-bit channels. Port A uses bank A, port B uses bank B and port C uses bank C, each with a line length of `BANK_DEPTH`. Words are read back in write order, and the pointers wrap.
- R3: A read cycle is one where `rd_en` is high and `rd_rst` is low. The word read appears on the port one cycle after the edge, with its lanes' enable bits set. After any other cycle, and after `rst_n`, every lane the channel owns reads 0 with its enable bit cleared.
- R4: A write reset or read reset has priority over the enable in the same cycle. It moves that pointer to word 0 and stores or returns nothing.
- R5: Code 1 is a 3-stage cascade driven only by port A's controls, with a line length of `BANK_DEPTH`. In a port A read cycle, port A returns the stored word, port B returns what port A returned one line of reads earlier, and port C returns what it returned two lines earlier. All three ports are driven together.
- R6: Code 2 chains stage A into stage B under port A's controls, as in R5, with stage B shown on port B. Port C is an independent 8-bit channel as in R2.
- R7: Code 3 gives two independent 12-bit channels. Channel 1 is controlled by port A; its word bits 11..4 come in and go out on port A bits 7..0, and its bits 3..0 on port B bits 3..0. Channel 2 is controlled by port B; its bits 11..4 use port C bits 7..0 and its bits 3..0 use port B bits 7..4.
- R8: Code 4 is a 12-bit 2-stage cascade under port A's controls. Stage 1 uses the lanes of channel 1 in R7, and stage 2 shows the word from one line earlier on the lanes of channel 2 in R7.
- R9: Code 5 gives one 8-bit channel on port A with a line length of 3×`BANK_DEPTH`. Ports B and C are never driven.
- R10: Code 6 gives an 8-bit channel on port A with a line length of 2×`BANK_DEPTH`, and an independent channel on port C with a line length of `BANK_DEPTH`. Port B is never driven.
- R11: Code 7 gives one 12-bit channel with a line length of 2×`BANK_DEPTH`, on the lanes of channel 1 in R7. Port B bits 7..4 and all of port C are never driven.
- R12: Data and control inputs of a port that owns no channel in the current mode have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all ports |
| rst_n | input | 1 | Active-low reset of pointers, outputs and mode |
| mode_sel | input | 3 | Arrangement code 0..7 |
| wr_en | input | 3 | Write enable per port (bit 0 A, 1 B, 2 C) |
| wr_rst | input | 3 | Write pointer reset per port |
| rd_en | input | 3 | Read enable per port |
| rd_rst | input | 3 | Read pointer reset per port |
| din_a | input | 8 | Port A write data |
| din_b | input | 8 | Port B write data |
| din_c | input | 8 | Port C write data |
| dout_a | output | 8 | Port A read data |
| dout_b | output | 8 | Port B read data |
| dout_c | output | 8 | Port C read data |
| dout_oe_a | output | 2 | Port A lane drive flags (bit 0 low nibble) |
| dout_oe_b | output | 2 | Port B lane drive flags |
| dout_oe_c | output | 2 | Port C lane drive flags |

## Verification
The bench builds the block with `BANK_DEPTH` = 16. With that depth the longest line is 48 words, so a few hundred random cycles per mode wrap every pointer several times. The same cycles carry the cascade stages through more than two full lines, so the second and third delayed outputs carry real data. The small depth also means that bank-select crossings, in the deep and double-depth modes, happen every sixteen words and are exercised many times alongside random pointer resets.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

    typedef enum logic [2:0] {
        M_TRIO      = 3'd0,
        M_CAS3      = 3'd1,
        M_CAS2_IND  = 3'd2,
        M_WIDE2     = 3'd3,
        M_WIDE_CAS  = 3'd4,
        M_DEEP3     = 3'd5,
        M_DEEP2_IND = 3'd6,
        M_WIDE_DEEP = 3'd7
    } mode_e;

    // Does port p own a channel in mode m
    function automatic logic chan_on(mode_e m, int p);
        case (p)
            0:       return 1'b1;
            1:       return (m == M_TRIO) || (m == M_WIDE2);
            default: return (m == M_TRIO) || (m == M_CAS2_IND) || (m == M_DEEP2_IND);
        endcase
    endfunction

    function automatic logic is_wide(mode_e m);
        return (m == M_WIDE2) || (m == M_WIDE_CAS) || (m == M_WIDE_DEEP);
    endfunction

    function automatic logic is_cascade(mode_e m);
        return (m == M_CAS3) || (m == M_CAS2_IND) || (m == M_WIDE_CAS);
    endfunction

    // Number of banks concatenated behind port A's channel
    function automatic logic [1:0] line_banks(mode_e m);
        case (m)
            M_DEEP3:                  return 2'd3;
            M_DEEP2_IND, M_WIDE_DEEP: return 2'd2;
            default:                  return 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/tmb_nib_store.sv
module tmb_nib_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [3:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [3:0]    rdata
);
    logic [3:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    // Read returns the old word when written in the same cycle
    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tmb_raddr_route.sv
module tmb_raddr_route
    import tmb_pkg::*;
#(
    parameter int AW = 4
) (
    input  mode_e                mode,
    input  logic [AW-1:0]        idx_a,
    input  logic [AW-1:0]        idx_b,
    input  logic [AW-1:0]        idx_c,
    output logic [5:0][AW-1:0]   raddr
);
    // Nibble stores: 0/1 bank A lo/hi, 2/3 bank B lo/hi, 4/5 bank C lo/hi
    always_comb begin
        for (int n = 0; n < 6; n++) raddr[n] = idx_a;
        case (mode)
            M_TRIO: begin
                raddr[2] = idx_b;
                raddr[3] = idx_b;
                raddr[4] = idx_c;
                raddr[5] = idx_c;
            end
            M_CAS2_IND, M_DEEP2_IND: begin
                raddr[4] = idx_c;
                raddr[5] = idx_c;
            end
            M_WIDE2: begin
                raddr[3] = idx_b;
                raddr[4] = idx_b;
                raddr[5] = idx_b;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tri_bank_fifo.sv
module tri_bank_fifo
    import tmb_pkg::*;
#(
    parameter int BANK_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic [2:0] wr_en,
    input  logic [2:0] wr_rst,
    input  logic [2:0] rd_en,
    input  logic [2:0] rd_rst,
    input  logic [7:0] din_a,
    input  logic [7:0] din_b,
    input  logic [7:0] din_c,
    output logic [7:0] dout_a,
    output logic [7:0] dout_b,
    output logic [7:0] dout_c,
    output logic [1:0] dout_oe_a,
    output logic [1:0] dout_oe_b,
    output logic [1:0] dout_oe_c
);
    localparam int AW = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;

    typedef struct packed {
        logic [1:0]    sel;
        logic [AW-1:0] idx;
    } ptr_t;

    typedef struct packed {
        mode_e          mode;
        ptr_t [2:0]     wp;
        ptr_t [2:0]     rp;
        logic [2:0][7:0] dq;
        logic [2:0][1:0] oe;
    } state_t;

    state_t s_d, s_q;

    logic [5:0][3:0]    rdata;
    logic [5:0][AW-1:0] raddr;
    logic [5:0]         nib_we;
    logic [5:0][AW-1:0] nib_waddr;
    logic [5:0][3:0]    nib_wdata;

    logic [2:0]          w8_on;
    logic [2:0][AW-1:0]  w8_addr;
    logic [2:0][7:0]     w8_data;
    logic [1:0]          w12_on;
    logic [1:0][AW-1:0]  w12_addr;
    logic [1:0][11:0]    w12_data;

    function automatic ptr_t step(ptr_t p, logic [1:0] nb);
        ptr_t n = p;
        if (p.idx == AW'(BANK_DEPTH - 1)) begin
            n.idx = '0;
            n.sel = (p.sel == nb - 2'd1) ? 2'd0 : p.sel + 2'd1;
        end else begin
            n.idx = p.idx + 1'b1;
        end
        return n;
    endfunction

    function automatic logic [7:0] r8(logic [5:0][3:0] r, int b);
        return {r[2*b+1], r[2*b]};
    endfunction

    // 12-bit word: bits 11..4 from a byte bank, bits 3..0 from half of bank B
    function automatic logic [11:0] r12(logic [5:0][3:0] r, logic s);
        return s ? {r[5], r[4], r[3]} : {r[1], r[0], r[2]};
    endfunction

    tmb_raddr_route #(.AW(AW)) i_route (
        .mode  (s_q.mode),
        .idx_a (s_q.rp[0].idx),
        .idx_b (s_q.rp[1].idx),
        .idx_c (s_q.rp[2].idx),
        .raddr (raddr)
    );

    for (genvar n = 0; n < 6; n++) begin : g_nib
        tmb_nib_store #(.DEPTH(BANK_DEPTH), .AW(AW)) i_store (
            .clk   (clk),
            .we    (nib_we[n]),
            .waddr (nib_waddr[n]),
            .wdata (nib_wdata[n]),
            .raddr (raddr[n]),
            .rdata (rdata[n])
        );
    end

    always_comb begin
        logic [2:0]  go_w, go_r;
        logic [11:0] w1, w2;
        logic        slot;
        s_d      = s_q;
        s_d.dq   = '0;
        s_d.oe   = '0;
        w8_on    = '0;
        w8_addr  = '0;
        w8_data  = '0;
        w12_on   = '0;
        w12_addr = '0;
        w12_data = '0;
        go_w     = wr_en & ~wr_rst;   // R4: reset wins
        go_r     = rd_en & ~rd_rst;
        slot     = (s_q.mode == M_WIDE_DEEP) ? s_q.rp[0].sel[0] : 1'b0;
        w1       = r12(rdata, slot);
        w2       = r12(rdata, 1'b1);

        // ---- writes from the ports
        if (go_w[0]) begin
            if (is_wide(s_q.mode)) begin
                w12_on[s_q.wp[0].sel[0]]   = 1'b1;
                w12_addr[s_q.wp[0].sel[0]] = s_q.wp[0].idx;
                w12_data[s_q.wp[0].sel[0]] = {din_a, din_b[3:0]};   // R7
            end else if (s_q.wp[0].sel < 2'd3) begin
                w8_on[s_q.wp[0].sel]   = 1'b1;
                w8_addr[s_q.wp[0].sel] = s_q.wp[0].idx;
                w8_data[s_q.wp[0].sel] = din_a;
            end
        end
        if (go_w[1] && chan_on(s_q.mode, 1)) begin                // R12
            if (is_wide(s_q.mode)) begin
                w12_on[1]   = 1'b1;
                w12_addr[1] = s_q.wp[1].idx;
                w12_data[1] = {din_c, din_b[7:4]};
            end else begin
                w8_on[1]   = 1'b1;
                w8_addr[1] = s_q.wp[1].idx;
                w8_data[1] = din_b;
            end
        end
        if (go_w[2] && chan_on(s_q.mode, 2)) begin
            w8_on[2]   = 1'b1;
            w8_addr[2] = s_q.wp[2].idx;
            w8_data[2] = din_c;
        end

        // ---- cascade transfers ride on port A's read (R5, R6, R8)
        if (go_r[0] && is_cascade(s_q.mode)) begin
            case (s_q.mode)
                M_CAS3: begin
                    w8_on[1] = 1'b1; w8_addr[1] = s_q.rp[0].idx; w8_data[1] = r8(rdata, 0);
                    w8_on[2] = 1'b1; w8_addr[2] = s_q.rp[0].idx; w8_data[2] = r8(rdata, 1);
                end
                M_CAS2_IND: begin
                    w8_on[1] = 1'b1; w8_addr[1] = s_q.rp[0].idx; w8_data[1] = r8(rdata, 0);
                end
                default: begin
                    w12_on[1] = 1'b1; w12_addr[1] = s_q.rp[0].idx; w12_data[1] = r12(rdata, 1'b0);
                end
            endcase
        end

        // ---- read outputs (R3)
        if (go_r[0]) begin
            case (s_q.mode)
                M_CAS3: begin
                    s_d.dq[0] = r8(rdata, 0); s_d.dq[1] = r8(rdata, 1); s_d.dq[2] = r8(rdata, 2);
                    s_d.oe[0] = 2'b11; s_d.oe[1] = 2'b11; s_d.oe[2] = 2'b11;
                end
                M_CAS2_IND: begin
                    s_d.dq[0] = r8(rdata, 0); s_d.dq[1] = r8(rdata, 1);
                    s_d.oe[0] = 2'b11; s_d.oe[1] = 2'b11;
                end
                M_WIDE2, M_WIDE_DEEP, M_WIDE_CAS: begin
                    s_d.dq[0]      = w1[11:4];
                    s_d.dq[1][3:0] = w1[3:0];
                    s_d.oe[0]      = 2'b11;
                    s_d.oe[1][0]   = 1'b1;
                    if (s_q.mode == M_WIDE_CAS) begin
                        s_d.dq[2]      = w2[11:4];
                        s_d.dq[1][7:4] = w2[3:0];
                        s_d.oe[2]      = 2'b11;
                        s_d.oe[1][1]   = 1'b1;
                    end
                end
                default: begin
                    s_d.dq[0] = r8(rdata, int'(s_q.rp[0].sel));
                    s_d.oe[0] = 2'b11;
                end
            endcase
        end
        if (go_r[1] && chan_on(s_q.mode, 1)) begin
            if (is_wide(s_q.mode)) begin
                s_d.dq[2]      = w2[11:4];
                s_d.dq[1][7:4] = w2[3:0];
                s_d.oe[2]      = 2'b11;
                s_d.oe[1][1]   = 1'b1;
            end else begin
                s_d.dq[1] = r8(rdata, 1);
                s_d.oe[1] = 2'b11;
            end
        end
        if (go_r[2] && chan_on(s_q.mode, 2)) begin
            s_d.dq[2] = r8(rdata, 2);
            s_d.oe[2] = 2'b11;
        end

        // ---- pointers (R4)
        for (int p = 0; p < 3; p++) begin
            logic [1:0] nb;
            nb = (p == 0) ? line_banks(s_q.mode) : 2'd1;
            if (wr_rst[p])                               s_d.wp[p] = '0;
            else if (go_w[p] && chan_on(s_q.mode, p))    s_d.wp[p] = step(s_q.wp[p], nb);
            if (rd_rst[p])                               s_d.rp[p] = '0;
            else if (go_r[p] && chan_on(s_q.mode, p))    s_d.rp[p] = step(s_q.rp[p], nb);
        end

        // ---- mode capture (R1)
        if (&{wr_rst, rd_rst}) s_d.mode = mode_e'(mode_sel);
    end

    // Nibble write ports
    always_comb begin
        for (int b = 0; b < 3; b++) begin
            nib_we[2*b]      = w8_on[b];
            nib_we[2*b+1]    = w8_on[b];
            nib_waddr[2*b]   = w8_addr[b];
            nib_waddr[2*b+1] = w8_addr[b];
            nib_wdata[2*b]   = w8_data[b][3:0];
            nib_wdata[2*b+1] = w8_data[b][7:4];
        end
        if (w12_on[0]) begin
            nib_we[1] = 1'b1; nib_waddr[1] = w12_addr[0]; nib_wdata[1] = w12_data[0][11:8];
            nib_we[0] = 1'b1; nib_waddr[0] = w12_addr[0]; nib_wdata[0] = w12_data[0][7:4];
            nib_we[2] = 1'b1; nib_waddr[2] = w12_addr[0]; nib_wdata[2] = w12_data[0][3:0];
        end
        if (w12_on[1]) begin
            nib_we[5] = 1'b1; nib_waddr[5] = w12_addr[1]; nib_wdata[5] = w12_data[1][11:8];
            nib_we[4] = 1'b1; nib_waddr[4] = w12_addr[1]; nib_wdata[4] = w12_data[1][7:4];
            nib_we[3] = 1'b1; nib_waddr[3] = w12_addr[1]; nib_wdata[3] = w12_data[1][3:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout_a    = s_q.dq[0];
    assign dout_b    = s_q.dq[1];
    assign dout_c    = s_q.dq[2];
    assign dout_oe_a = s_q.oe[0];
    assign dout_oe_b = s_q.oe[1];
    assign dout_oe_c = s_q.oe[2];
endmodule

// File: rtl/tri_bank_fifo_chk.sv
module tri_bank_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_q,
    input logic [2:0] wr_rst,
    input logic [2:0] rd_en,
    input logic [2:0] rd_rst,
    input logic [1:0] dout_oe_a,
    input logic [1:0] dout_oe_b,
    input logic [1:0] dout_oe_c
);
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(&{wr_rst, rd_rst}) |=> $stable(mode_q));                                  // R1
    AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe_a != 2'b00) |-> $past(rd_en[0] && !rd_rst[0]));                  // R3
    AST_CAS3_ALL_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd1 && dout_oe_a != 2'b00) |-> (dout_oe_b == 2'b11 && dout_oe_c == 2'b11)); // R5
    AST_DEEP3_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd5) |-> (dout_oe_b == 2'b00 && dout_oe_c == 2'b00));         // R9
    AST_DEEP2_B_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd6) |-> (dout_oe_b == 2'b00));                                 // R10
    AST_WIDE_DEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd7) |-> (dout_oe_b[1] == 1'b0 && dout_oe_c == 2'b00));       // R11
    AST_CAS3_IGNORES_C: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd1) |-> (dout_oe_c == dout_oe_a));                             // R12
endmodule

bind tri_bank_fifo tri_bank_fifo_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (s_q.mode),
    .wr_rst    (wr_rst),
    .rd_en     (rd_en),
    .rd_rst    (rd_rst),
    .dout_oe_a (dout_oe_a),
    .dout_oe_b (dout_oe_b),
    .dout_oe_c (dout_oe_c)
);

// File: tb/test_tri_bank_fifo.sv
module test_tri_bank_fifo;
    localparam int D = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = '0;
    logic [2:0] wen = '0, wrst = '0, ren = '0, rrst = '0;
    logic [7:0] din_a = '0, din_b = '0, din_c = '0;
    logic [7:0] dout_a, dout_b, dout_c;
    logic [1:0] dout_oe_a, dout_oe_b, dout_oe_c;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    tri_bank_fifo #(.BANK_DEPTH(D)) i_tri_bank_fifo (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .wr_en(wen), .wr_rst(wrst), .rd_en(ren), .rd_rst(rrst),
        .din_a(din_a), .din_b(din_b), .din_c(din_c),
        .dout_a(dout_a), .dout_b(dout_b), .dout_c(dout_c),
        .dout_oe_a(dout_oe_a), .dout_oe_b(dout_oe_b), .dout_oe_c(dout_oe_c)
    );

    // ---------------- reference model ----------------
    logic [11:0] mm [3][3*D];
    bit          mv [3][3*D];
    logic [11:0] cs [2][D];
    bit          cv [2][D];
    int          mwp [3], mrp [3];
    int          mmode = 0;
    logic [7:0]  e_d  [3];
    logic [1:0]  e_oe [3];
    logic [1:0]  e_k  [3];
    string       cur_req = "R2";

    function automatic bit on(int m, int p);
        if (p == 0) return 1;
        if (p == 1) return (m == 0) || (m == 3);
        return (m == 0) || (m == 2) || (m == 6);
    endfunction

    function automatic int ll(int m, int p);
        if (p != 0) return D;
        if (m == 5) return 3 * D;
        if (m == 6 || m == 7) return 2 * D;
        return D;
    endfunction

    function automatic bit wide(int m);
        return (m == 3) || (m == 4) || (m == 7);
    endfunction

    function automatic string mode_req(int m);
        case (m)
            0: return "R2";  1: return "R5";  2: return "R6";  3: return "R7";
            4: return "R8";  5: return "R9";  6: return "R10"; default: return "R11";
        endcase
    endfunction

    function automatic void set8(int p, logic [7:0] v, bit k);
        e_d[p] = v; e_oe[p] = 2'b11; e_k[p] = {k, k};
    endfunction

    // 12-bit word: 11..4 on byte port p8, 3..0 on port B nibble hi
    function automatic void set12(int p8, bit hi, logic [11:0] w, bit k);
        e_d[p8] = w[11:4]; e_oe[p8] = 2'b11; e_k[p8] = {k, k};
        if (hi) begin e_d[1][7:4] = w[3:0]; e_oe[1][1] = 1'b1; e_k[1][1] = k; end
        else    begin e_d[1][3:0] = w[3:0]; e_oe[1][0] = 1'b1; e_k[1][0] = k; end
    endfunction

    function automatic logic [11:0] dword(int m, int p);
        if (p == 0) return wide(m) ? {din_a, din_b[3:0]} : {4'h0, din_a};
        if (p == 1) return wide(m) ? {din_c, din_b[7:4]} : {4'h0, din_b};
        return {4'h0, din_c};
    endfunction

    function automatic void model_step();
        int m = mmode;
        cur_req = mode_req(m);
        for (int p = 0; p < 3; p++) begin e_d[p] = '0; e_oe[p] = '0; e_k[p] = 2'b11; end
        for (int p = 0; p < 3; p++) begin
            if (rrst[p]) mrp[p] = 0;
            else if (on(m, p) && ren[p]) begin
                logic [11:0] w, s1, s2;
                bit v, v1, v2;
                int a = mrp[p];
                w = mm[p][a]; v = mv[p][a];
                s1 = '0; s2 = '0; v1 = 0; v2 = 0;
                if (p == 0 && (m == 1 || m == 2 || m == 4)) begin
                    s1 = cs[0][a]; v1 = cv[0][a]; s2 = cs[1][a]; v2 = cv[1][a];
                    if (m == 1) begin cs[1][a] = s1; cv[1][a] = v1; end
                    cs[0][a] = w; cv[0][a] = v;
                end
                if (p == 0) begin
                    case (m)
                        1: begin set8(0, w[7:0], v); set8(1, s1[7:0], v1); set8(2, s2[7:0], v2); end
                        2: begin set8(0, w[7:0], v); set8(1, s1[7:0], v1); end
                        3, 7: set12(0, 0, w, v);
                        4: begin set12(0, 0, w, v); set12(2, 1, s1, v1); end
                        default: set8(0, w[7:0], v);
                    endcase
                end else if (p == 1) begin
                    if (m == 3) set12(2, 1, w, v); else set8(1, w[7:0], v);
                end else begin
                    set8(2, w[7:0], v);
                end
                mrp[p] = (a + 1) % ll(m, p);
            end
        end
        for (int p = 0; p < 3; p++) begin
            if (wrst[p]) mwp[p] = 0;
            else if (on(m, p) && wen[p]) begin
                mm[p][mwp[p]] = dword(m, p);
                mv[p][mwp[p]] = 1;
                mwp[p] = (mwp[p] + 1) % ll(m, p);
            end
        end
        if (&{wrst, rrst} && int'(mode_sel) != mmode) begin
            mmode = int'(mode_sel);
            for (int p = 0; p < 3; p++) for (int a = 0; a < 3 * D; a++) mv[p][a] = 0;
            for (int s = 0; s < 2; s++) for (int a = 0; a < D; a++) cv[s][a] = 0;
        end
    endfunction

    // ---------------- checking ----------------
    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cmp_port(int p, logic [7:0] ad, logic [1:0] aoe);
        chk("R3", $sformatf("oe port %0d", p), {6'd0, aoe}, {6'd0, e_oe[p]});
        if (e_k[p][0]) chk(cur_req, $sformatf("data lo port %0d", p), {4'd0, ad[3:0]}, {4'd0, e_d[p][3:0]});
        if (e_k[p][1]) chk(cur_req, $sformatf("data hi port %0d", p), {4'd0, ad[7:4]}, {4'd0, e_d[p][7:4]});
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        #1;
        cmp_port(0, dout_a, dout_oe_a);
        cmp_port(1, dout_b, dout_oe_b);
        cmp_port(2, dout_c, dout_oe_c);
    endtask

    task automatic idle();
        wen = '0; wrst = '0; ren = '0; rrst = '0;
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < 3; p++) begin
            mwp[p] = 0; mrp[p] = 0;
            for (int a = 0; a < 3 * D; a++) mv[p][a] = 0;
        end
        for (int s = 0; s < 2; s++) for (int a = 0; a < D; a++) cv[s][a] = 0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // Reset state: R3
        chk("R3", "reset dout_a", dout_a, 8'h00);
        chk("R3", "reset dout_b", dout_b, 8'h00);
        chk("R3", "reset dout_c", dout_c, 8'h00);
        chk("R3", "reset oe", {2'b0, dout_oe_a, dout_oe_b, dout_oe_c}, 8'h00);

        for (int m = 0; m < 8; m++) begin
            idle();
            mode_sel = 3'(m);
            wrst = 3'b111; rrst = 3'b111;
            cycle(); cycle();
            idle();
            for (int k = 0; k < 300; k++) begin
                for (int p = 0; p < 3; p++) begin
                    wen[p]  = ($urandom % 10) < 8;
                    ren[p]  = ($urandom % 10) < 6;
                    wrst[p] = ($urandom % 97) == 0;
                    rrst[p] = ($urandom % 97) == 0;
                end
                din_a = 8'($urandom); din_b = 8'($urandom); din_c = 8'($urandom);
                cycle();
            end
            idle();
            cycle();
            if (m == 0) begin
                // R4: reset beats enable, then word 0 holds the next write
                wrst[0] = 1'b1; wen[0] = 1'b1; din_a = 8'h3C; cycle();
                wrst[0] = 1'b0; din_a = 8'hA5; cycle();
                wen[0] = 1'b0; rrst[0] = 1'b1; ren[0] = 1'b1; cycle();
                rrst[0] = 1'b0; cycle();
                chk("R4", "word 0 after resets", dout_a, 8'hA5);
                idle(); cycle();
            end
            if (m == 1) begin
                // R12: port B/C controls do nothing in the 3-stage cascade
                ren = 3'b110; wen = 3'b110; din_b = 8'h5A; din_c = 8'hC3; cycle();
                chk("R12", "oe b,c with idle A", {4'b0, dout_oe_b, dout_oe_c}, 8'h00);
                idle(); cycle();
            end
            if (m == 5) begin
                // R1: mode code change without full reset is not taken
                mode_sel = 3'd0;
                ren = 3'b110; wen = 3'b110; cycle();
                chk("R1", "oe b after ignored mode change", {6'b0, dout_oe_b}, 8'h00);
                cycle();
                chk("R1", "oe c after ignored mode change", {6'b0, dout_oe_c}, 8'h00);
                idle(); mode_sel = 3'd5; cycle();
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule